// File: doc/BRIEF.md
# Dual-Byte Timer with Variable-Width PWM

This block is a 16-bit counter engine split into a low byte and a high byte. It runs in one of four modes. Mode 0 gives two independent 8-bit interval timers. Mode 1 gives an 8-bit interval timer on the low byte and an 8-bit pulse-width modulator on the high byte. Mode 2 gives one 16-bit interval timer. Mode 3 gives a pulse-width modulator whose period is 2^N counts, where N is programmable from 9 to 16. The counter advances on strobes from the clock system. A one-instruction-cycle strobe is always available. A half-cycle strobe can replace it in the two wide modes, which doubles the count rate.

Software programs the block through a small write port with four addresses. Address 0 is a control byte. Address 1 is a low data byte and address 2 is a high data byte; these two bytes act as interval lengths or duty values, depending on the mode. Address 3 clears the flags when a 1 is written to a bit. A modulated waveform is driven on one output pin. Two sticky interrupt flags report the period events of the low and high halves.

Top module: `tpwm_top`

## Requirements
- R1: After reset, `pwm_out`, `irq_lo` and `irq_hi` are all 0 and both counter bytes are 0.
- R2: Address 0 holds the control byte: bits [1:0] are the mode, bit 2 selects the fast rate, bits [6:4] are the width code W (period exponent N = 9 + W), and bit 7 is run. Address 1 is the low data byte and address 2 is the high data byte. Any write to address 0 returns both counter bytes to 0 and snapshots {high, low} as the active duty.
- R3: In mode 0, the low byte counts 0 up to the low data byte and then wraps, so its interval is low+1 steps, and it sets `irq_lo` on the wrap. The high byte does the same on its own with the high data byte and `irq_hi`. `pwm_out` stays 0.
- R4: In mode 1, the low byte is the mode 0 low timer. The high byte counts freely through 256 steps. `pwm_out` is 1 while the high count is below the active duty's high byte, and `irq_hi` is set each time the high count wraps from 255 to 0.
- R5: In mode 2, the two bytes form one 16-bit counter running from 0 to {high, low}, so the interval is {high, low}+1 steps. `irq_hi` is set on the wrap, `irq_lo` is never set, and `pwm_out` stays 0.
- R6: In mode 3, the 16-bit counter runs through 2^N steps. `pwm_out` is 1 while the count is below the 16-bit active duty, so a duty at or above 2^N keeps it high. `irq_hi` is set at the end of each period and the counter wraps to 0.
- R7: In the modulator modes, a data byte written in the middle of a period does not change the waveform until the next period begins. At that boundary the active duty is reloaded from {high, low}.
- R8: Modes 0 and 1 step only on `tick_cyc`, whatever the value of the fast bit. In modes 2 and 3 with the fast bit set, the counter steps on `tick_half` instead.
- R9: A 1 written to bit 0 or bit 1 at address 3 clears `irq_lo` or `irq_hi` respectively, and a 0 leaves the flag unchanged. If a period event and a clear of the same flag fall in one cycle, the flag ends up set.
- R10: When run is 0, the counter holds its value, no flag is set by a period event, and `pwm_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_cyc | input | 1 | One-instruction-cycle step strobe |
| tick_half | input | 1 | Half-instruction-cycle step strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address (0 control, 1 low, 2 high, 3 flag clear) |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Modulated output |
| irq_lo | output | 1 | Low-half period flag |
| irq_hi | output | 1 | High-half / wide period flag |

## Verification
A period event can land in the same clock as a software write that clears the flag it sets. This is the coincidence that matters most. The bench provokes it by running mode 0 with an interval of one step, so an event occurs on every tick. It then drives a tick and a clear of `irq_lo` together at one falling edge and expects the flag to read 1 afterwards; a later clear with no tick must drop it. A second overlap happens when a duty value is written partway through a modulator period. The bench judges it by counting the high steps in the rest of that period, which must match the old duty, and in the following period, which must match the new duty.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int BYTE_W  = 8;
  localparam int WIDE_W  = 2 * BYTE_W;
  localparam int WCODE_W = 3;
  localparam int ADDR_W  = 2;
  localparam int NFLAG   = 2;

  typedef enum logic [1:0] {
    M_DUAL8   = 2'd0,
    M_T8_PWM8 = 2'd1,
    M_T16     = 2'd2,
    M_PWMVAR  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic               run;
    logic [WCODE_W-1:0] wcode;
    logic               spare;
    logic               fast;
    tmode_e             mode;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;

  // Last count of a 2^(9+wcode) period.
  function automatic logic [WIDE_W-1:0] span_top(input logic [WCODE_W-1:0] wcode);
    logic [WIDE_W-1:0] ones;
    ones = '1;
    return ones >> (3'd7 - wcode);
  endfunction

  // Output level for a given count and duty.
  function automatic logic pwm_level(input logic [WIDE_W-1:0] cnt,
                                     input logic [WIDE_W-1:0] duty);
    return cnt < duty;
  endfunction

  // Half-cycle stepping only applies to the wide modes.
  function automatic logic uses_half(input ctrl_t c);
    return c.fast && c.mode[1];
  endfunction
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
  import tpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [BYTE_W-1:0] reg_lo,
  output logic [BYTE_W-1:0] reg_hi,
  output logic              restart,
  output logic [NFLAG-1:0]  clr
);
  assign restart = wr_en && (wr_addr == A_CTRL);
  assign clr     = (wr_en && (wr_addr == A_CLR)) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reg_lo <= '0;
      reg_hi <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL:  ctrl   <= ctrl_t'(wr_data);
        A_LO:    reg_lo <= wr_data;
        A_HI:    reg_hi <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tpwm_count.sv
module tpwm_count
  import tpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  ctrl_t             ctrl,
  input  logic [BYTE_W-1:0] reg_lo,
  input  logic [BYTE_W-1:0] reg_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ev_lo,
  output logic              ev_hi,
  output logic              pwm_out
);
  logic [WIDE_W-1:0] cnt16, per16, top16, duty_act, inc16;
  logic [BYTE_W-1:0] nxt_lo, nxt_hi;
  logic              lo_match, hi_match, pwm_mode;

  assign cnt16    = {cnt_hi, cnt_lo};
  assign per16    = {reg_hi, reg_lo};
  assign top16    = span_top(ctrl.wcode);
  assign inc16    = cnt16 + 16'd1;
  assign lo_match = (cnt_lo == reg_lo);
  assign hi_match = (cnt_hi == reg_hi);
  assign pwm_mode = ctrl.mode[0];

  always_comb begin
    nxt_lo = cnt_lo;
    nxt_hi = cnt_hi;
    ev_lo  = 1'b0;
    ev_hi  = 1'b0;
    unique case (ctrl.mode)
      M_DUAL8: begin
        ev_lo = step && lo_match;
        ev_hi = step && hi_match;
        if (step) begin
          nxt_lo = lo_match ? '0 : BYTE_W'(cnt_lo + 8'd1);
          nxt_hi = hi_match ? '0 : BYTE_W'(cnt_hi + 8'd1);
        end
      end
      M_T8_PWM8: begin
        ev_lo = step && lo_match;
        ev_hi = step && (cnt_hi == '1);
        if (step) begin
          nxt_lo = lo_match ? '0 : BYTE_W'(cnt_lo + 8'd1);
          nxt_hi = BYTE_W'(cnt_hi + 8'd1);
        end
      end
      M_T16: begin
        ev_hi = step && (cnt16 == per16);
        if (step) {nxt_hi, nxt_lo} = ev_hi ? '0 : inc16;
      end
      M_PWMVAR: begin
        ev_hi = step && (cnt16 == top16);
        if (step) {nxt_hi, nxt_lo} = ev_hi ? '0 : inc16;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo   <= '0;
      cnt_hi   <= '0;
      duty_act <= '0;
    end else if (restart) begin
      cnt_lo   <= '0;
      cnt_hi   <= '0;
      duty_act <= per16;
    end else begin
      cnt_lo <= nxt_lo;
      cnt_hi <= nxt_hi;
      if (pwm_mode && ev_hi) duty_act <= per16;
    end
  end

  always_comb begin
    unique case (ctrl.mode)
      M_T8_PWM8: pwm_out = pwm_level({8'h00, cnt_hi}, {8'h00, duty_act[WIDE_W-1:BYTE_W]});
      M_PWMVAR:  pwm_out = pwm_level(cnt16, duty_act);
      default:   pwm_out = 1'b0;
    endcase
    pwm_out = pwm_out && ctrl.run;
  end
endmodule

// File: rtl/tpwm_flags.sv
module tpwm_flags
  import tpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flags
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
  import tpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_cyc,
  input  logic              tick_half,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              irq_lo,
  output logic              irq_hi
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] reg_lo, reg_hi, cnt_lo, cnt_hi;
  logic              restart, step, ev_lo, ev_hi;
  logic [NFLAG-1:0]  clr, flags;

  // Named internal events for the checker.
  logic [1:0]        mode_now;
  logic              run_now;
  logic [WIDE_W-1:0] count_now;

  tpwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .reg_lo(reg_lo), .reg_hi(reg_hi), .restart(restart), .clr(clr)
  );

  assign step = ctrl.run && !restart && (uses_half(ctrl) ? tick_half : tick_cyc);

  tpwm_count u_count (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(restart), .ctrl(ctrl),
    .reg_lo(reg_lo), .reg_hi(reg_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ev_lo(ev_lo), .ev_hi(ev_hi), .pwm_out(pwm_out)
  );

  tpwm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set({ev_hi, ev_lo}), .clr(clr), .flags(flags)
  );

  assign irq_lo    = flags[0];
  assign irq_hi    = flags[1];
  assign mode_now  = ctrl.mode;
  assign run_now   = ctrl.run;
  assign count_now = {cnt_hi, cnt_lo};
endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_cyc,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        step,
  input logic        restart,
  input logic        ev_lo,
  input logic        ev_hi,
  input logic [1:0]  mode_now,
  input logic        run_now,
  input logic [15:0] count_now,
  input logic        pwm_out,
  input logic        irq_lo,
  input logic        irq_hi
);
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_now == 16'd0)); // R2
  AST_TIMER_NO_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_now[0] |-> !pwm_out); // R3
  AST_WIDE_NO_LO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 2'd2) |-> !ev_lo); // R5
  AST_VAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hi && mode_now == 2'd3) |=> (count_now == 16'd0)); // R6
  AST_NARROW_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_now[1] && !tick_cyc) |-> !step); // R8
  AST_SET_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lo |=> irq_lo); // R9
  AST_SET_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi |=> irq_hi); // R9
  AST_CLEAR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && wr_data[0] && !ev_lo) |=> !irq_lo); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_now |-> !pwm_out); // R10
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(count_now)); // R10
endmodule

bind tpwm_top tpwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_cyc(tick_cyc), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .step(step), .restart(restart), .ev_lo(ev_lo), .ev_hi(ev_hi),
  .mode_now(mode_now), .run_now(run_now), .count_now(count_now),
  .pwm_out(pwm_out), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tpwm_top_tb_top.sv
module tpwm_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_cyc = 1'b0, tick_half = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, irq_lo, irq_hi;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {string req; int sel; int exp; int act;} item_t;
  item_t sbq[$];

  tpwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_cyc(tick_cyc), .tick_half(tick_half),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #10ns clk = ~clk;

  // Monitor: pops expectations and compares against the design.
  initial begin
    forever begin
      item_t it;
      int a;
      wait (sbq.size() > 0);
      it = sbq.pop_front();
      case (it.sel)
        0: a = int'(pwm_out);
        1: a = int'(irq_lo);
        2: a = int'(irq_hi);
        default: a = it.act;
      endcase
      n_run++;
      if (a != it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %0d expected %0d", it.req, a, it.exp);
      end
    end
  end

  task automatic expect_port(input string req, input int sel, input int exp);
    sbq.push_back('{req, sel, exp, 0});
    wait (sbq.size() == 0);
  endtask

  task automatic expect_val(input string req, input int exp, input int act);
    sbq.push_back('{req, 3, exp, act});
    wait (sbq.size() == 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // One instruction cycle: one full strobe and two half strobes.
  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk); tick_cyc = 1'b1; tick_half = 1'b1;
      @(negedge clk); tick_cyc = 1'b0; tick_half = 1'b1;
    end
    @(negedge clk); tick_half = 1'b0;
  endtask

  task automatic meas(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      hi += int'(pwm_out);
      cyc(1);
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int h1, h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_port("R1 pwm after reset", 0, 0);
    expect_port("R1 irq_lo after reset", 1, 0);
    expect_port("R1 irq_hi after reset", 2, 0);

    // Mode 0: two independent byte timers
    wr(2'd1, 8'd4); wr(2'd2, 8'd2); wr(2'd0, 8'h80);
    cyc(2);  expect_port("R3 hi timer early", 2, 0);
    cyc(1);  expect_port("R3 hi timer at 3 steps", 2, 1);
    expect_port("R3 lo timer not yet", 1, 0);
    cyc(2);  expect_port("R3 lo timer at 5 steps", 1, 1);
    expect_port("R3 no pwm in mode 0", 0, 0);

    // Flag clearing
    wr(2'd3, 8'h01);
    expect_port("R9 clear lo", 1, 0);
    expect_port("R9 hi untouched", 2, 1);
    wr(2'd3, 8'h00);
    expect_port("R9 zero write no effect", 2, 1);
    wr(2'd3, 8'h02);
    expect_port("R9 clear hi", 2, 0);

    // Control write restarts the count
    wr(2'd3, 8'h03); wr(2'd0, 8'h80);
    cyc(3); wr(2'd0, 8'h80); cyc(3);
    expect_port("R2 restart delays lo event", 1, 0);
    cyc(2);
    expect_port("R2 lo event after restart", 1, 1);

    // Fast bit ignored in mode 0
    wr(2'd3, 8'h03); wr(2'd0, 8'h84);
    cyc(4); expect_port("R8 mode0 ignores fast", 1, 0);
    cyc(1); expect_port("R8 mode0 steps per cycle", 1, 1);

    // Mode 1: 8-bit modulator, duty 64
    wr(2'd3, 8'h03); wr(2'd2, 8'd64); wr(2'd1, 8'd200); wr(2'd0, 8'h81);
    meas(255, h1);
    expect_port("R4 no hi event before 256", 2, 0);
    meas(1, h2);
    expect_port("R4 hi event at 256", 2, 1);
    expect_val("R4 high steps duty 64", 64, h1 + h2);

    // Duty change mid-period
    wr(2'd0, 8'h81);
    meas(10, h1);
    wr(2'd2, 8'd200);
    meas(246, h2);
    expect_val("R7 old duty holds for period", 64, h1 + h2);
    meas(256, h1);
    expect_val("R7 new duty next period", 200, h1);

    // Mode 2: 16-bit interval 301
    wr(2'd3, 8'h03); wr(2'd1, 8'h2C); wr(2'd2, 8'h01); wr(2'd0, 8'h82);
    cyc(300); expect_port("R5 no event at 300", 2, 0);
    cyc(1);   expect_port("R5 event at 301", 2, 1);
    expect_port("R5 lo flag never set", 1, 0);
    wr(2'd3, 8'h03); wr(2'd0, 8'h86);
    cyc(150); expect_port("R8 fast mode2 at 300 half steps", 2, 0);
    cyc(1);   expect_port("R8 fast mode2 at 302 half steps", 2, 1);

    // Mode 3: N=9, duty 100
    wr(2'd3, 8'h03); wr(2'd1, 8'd100); wr(2'd2, 8'd0); wr(2'd0, 8'h83);
    meas(511, h1);
    expect_port("R6 no event before 512", 2, 0);
    meas(1, h2);
    expect_port("R6 event at 512", 2, 1);
    expect_val("R6 high steps duty 100", 100, h1 + h2);
    wr(2'd1, 8'h00); wr(2'd2, 8'h03); wr(2'd0, 8'h83);
    meas(512, h1);
    expect_val("R6 duty above span stays high", 512, h1);

    // Mode 3 fast, N=11
    wr(2'd3, 8'h03); wr(2'd0, 8'hA7);
    cyc(1023); expect_port("R6 N=11 fast before end", 2, 0);
    cyc(1);    expect_port("R6 N=11 fast at 2048", 2, 1);

    // Stopped
    wr(2'd3, 8'h03); wr(2'd0, 8'h03);
    expect_port("R10 pwm low when stopped", 0, 0);
    cyc(600);
    expect_port("R10 no event when stopped", 2, 0);

    // Event and clear in the same cycle
    wr(2'd3, 8'h03); wr(2'd1, 8'd0); wr(2'd0, 8'h80);
    @(negedge clk); tick_cyc = 1'b1; tick_half = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk); tick_cyc = 1'b0; tick_half = 1'b0; wr_en = 1'b0;
    expect_port("R9 set wins over clear", 1, 1);
    wr(2'd3, 8'h01);
    expect_port("R9 clear alone", 1, 0);

    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule